// File: doc/BRIEF.md
# Ring-Oscillator ADC Counter Back End

This block forms the digital half of a voltage-to-code converter built from two current-starved ring oscillators. One ring runs from the regulated output voltage and the other from the reference. Below threshold, a ring's frequency rises linearly with its supply current, so over a fixed window the number of rising edges it produces is proportional to its voltage. The block synchronises both ring clocks into the system clock domain and counts rising edges on each. At every sample strobe it subtracts the two window counts and emits a small signed error code with a one-cycle valid pulse.

The strobe runs at the loop sampling rate, nominally 500 kHz. One code step stands for roughly 16 mV of output error. The code is clamped to a narrow band of about ±50 mV around the reference, inside the roughly 100 mV span over which the rings stay linear. A digital loop filter downstream uses the code. The analog rings and level shifters are outside this block.

Top module: `ring_adc_backend`

## Requirements
- R1: When the clamp is not active, err_o equals the reference-ring count minus the output-ring count for the window just closed, as a two's-complement signed value of ERR_W bits. A positive code means the output voltage is below the reference.
- R2: Each ring input passes through a two-flop synchroniser. Only a low-to-high transition of the synchronised signal adds one to that ring's count. A ring held high or low adds nothing.
- R3: On a strobe cycle, both counts are captured and both counters are cleared in the same cycle. A rising edge detected in the strobe cycle belongs to the window that is closing. No edge is lost or counted twice across windows, even with strobes on consecutive cycles.
- R4: A difference above SAT_LIM (default 3) gives err_o = +SAT_LIM. A difference below -SAT_LIM gives err_o = -SAT_LIM.
- R5: valid_o is high for exactly the one cycle after each strobe cycle and low otherwise. err_o changes only together with valid_o and holds its value between samples.
- R6: While rst_ni is low, valid_o is 0, err_o is 0 and both counters are zero. After reset is released, counting starts from an empty window.
- R7: A ring count stops at 2^CNT_W-1 (255 by default) and does not wrap within a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_ring_i | input | 1 | Level-shifted ring clock driven by the output voltage |
| ref_ring_i | input | 1 | Level-shifted ring clock driven by the reference |
| strobe_i | input | 1 | Sample strobe; closes the window in the cycle it is high |
| err_o | output | ERR_W (3) | Signed, clamped error code (reference count minus output count) |
| valid_o | output | 1 | One-cycle pulse marking a new err_o |

## Verification
Some rules are checked on every cycle by the assertions:
- the valid pulse follows each strobe by exactly one cycle and appears at no other time;
- err_o stays inside the clamp band and does not move between samples;
- a counter is zero after a strobe and stays at its ceiling once it reaches it;
- the edge detector never fires on two cycles in a row.

The bench scenarios are the only place to show that the code values are right. These scenarios cover rings of unequal and equal rates, stopped rings, edges that land on the strobe cycle, back-to-back strobes, counters driven to their ceiling, and a reset applied while the rings are running.

// File: rtl/ring_adc_pkg.sv
package ring_adc_pkg;
  parameter int unsigned CNT_W_DEF   = 8;
  parameter int unsigned ERR_W_DEF   = 3;
  parameter int unsigned SAT_LIM_DEF = 3;
  parameter int unsigned N_RINGS     = 2;

  typedef enum int unsigned {
    RING_FB  = 0,
    RING_REF = 1
  } ring_idx_e;
endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= ring_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

  // R2: a detected edge cannot repeat on the next cycle
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/window_counter.sv
module window_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             strobe_i,
  output logic [CNT_W-1:0] win_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum       = {1'b0, cnt_q} + {{CNT_W{1'b0}}, rise_i};
  // strobe-cycle edge belongs to the closing window
  assign win_cnt_o = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (strobe_i) cnt_q <= '0;
    else               cnt_q <= win_cnt_o;
  end

  a_r3_clear_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (cnt_q == '0));

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/err_former.sv
module err_former #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned ERR_W   = 3,
  parameter int unsigned SAT_LIM = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    strobe_i,
  input  logic [CNT_W-1:0]        fb_cnt_i,
  input  logic [CNT_W-1:0]        ref_cnt_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    valid_o
);
  localparam logic signed [CNT_W:0]   HI_C   = (CNT_W+1)'(SAT_LIM);
  localparam logic signed [CNT_W:0]   LO_C   = -HI_C;
  localparam logic signed [ERR_W-1:0] ERR_HI = ERR_W'(SAT_LIM);
  localparam logic signed [ERR_W-1:0] ERR_LO = -ERR_HI;

  logic signed [CNT_W:0]   diff, clamped;
  logic signed [ERR_W-1:0] err_d;

  assign diff = $signed({1'b0, ref_cnt_i}) - $signed({1'b0, fb_cnt_i});

  always_comb begin
    if (diff > HI_C)      clamped = HI_C;
    else if (diff < LO_C) clamped = LO_C;
    else                  clamped = diff;
    err_d = clamped[ERR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) err_o <= err_d;
    end
  end

  a_r5_valid_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);

  a_r5_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !valid_o);

  a_r5_err_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(err_o));

  a_r4_err_in_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o <= ERR_HI) && (err_o >= ERR_LO));
endmodule

// File: rtl/ring_adc_backend.sv
module ring_adc_backend
  import ring_adc_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned ERR_W   = ERR_W_DEF,
  parameter int unsigned SAT_LIM = SAT_LIM_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fb_ring_i,
  input  logic                    ref_ring_i,
  input  logic                    strobe_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    valid_o
);
  logic [N_RINGS-1:0] ring_in;
  logic [N_RINGS-1:0] rise;
  logic [CNT_W-1:0]   win_cnt [N_RINGS];

  assign ring_in[RING_FB]  = fb_ring_i;
  assign ring_in[RING_REF] = ref_ring_i;

  for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
    ring_edge_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ring_i (ring_in[g]),
      .rise_o (rise[g])
    );

    window_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise[g]),
      .strobe_i  (strobe_i),
      .win_cnt_o (win_cnt[g])
    );
  end

  err_former #(
    .CNT_W   (CNT_W),
    .ERR_W   (ERR_W),
    .SAT_LIM (SAT_LIM)
  ) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe_i),
    .fb_cnt_i  (win_cnt[RING_FB]),
    .ref_cnt_i (win_cnt[RING_REF]),
    .err_o     (err_o),
    .valid_o   (valid_o)
  );
endmodule

// File: tb/sim_ring_adc_backend.sv
module sim_ring_adc_backend;
  localparam int CNT_W   = 8;
  localparam int ERR_W   = 3;
  localparam int SAT_LIM = 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fb_ring = 1'b0, ref_ring = 1'b0, strobe = 1'b0;
  logic signed [ERR_W-1:0] err;
  logic valid;

  always #2 clk = ~clk;

  ring_adc_backend #(.CNT_W(CNT_W), .ERR_W(ERR_W), .SAT_LIM(SAT_LIM)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fb_ring_i(fb_ring), .ref_ring_i(ref_ring),
    .strobe_i(strobe), .err_o(err), .valid_o(valid)
  );

  int n_run = 0, n_fail = 0;
  string cur_tag = "R1", err_tag = "R1";
  int fb_h[3], ref_h[3];
  int cnt_fb = 0, cnt_ref = 0, exp_err = 0, exp_valid = 0;
  int fb_half = 0, ref_half = 0, fb_ph = 0, ref_ph = 0;
  bit model_on = 0;

  task automatic check(bit ok, string req, int act, int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin fb_h[i] = 0; ref_h[i] = 0; end
    cnt_fb = 0; cnt_ref = 0; exp_err = 0; exp_valid = 0;
  endtask

  // called after an active edge; inputs still hold what that edge sampled
  task automatic model_step();
    int pf, pr, tf, tr, d;
    pf = (fb_h[1] == 1 && fb_h[2] == 0) ? 1 : 0;
    pr = (ref_h[1] == 1 && ref_h[2] == 0) ? 1 : 0;
    tf = (cnt_fb + pf > CNT_MAX) ? CNT_MAX : cnt_fb + pf;
    tr = (cnt_ref + pr > CNT_MAX) ? CNT_MAX : cnt_ref + pr;
    if (strobe) begin
      d = tr - tf;
      err_tag = cur_tag;
      if (d > SAT_LIM || d < -SAT_LIM) err_tag = "R4";
      if (tf == CNT_MAX || tr == CNT_MAX) err_tag = "R7";
      exp_err = (d > SAT_LIM) ? SAT_LIM : (d < -SAT_LIM) ? -SAT_LIM : d;
      exp_valid = 1;
      cnt_fb = 0; cnt_ref = 0;
    end else begin
      exp_valid = 0;
      cnt_fb = tf; cnt_ref = tr;
    end
    fb_h[2] = fb_h[1]; fb_h[1] = fb_h[0]; fb_h[0] = int'(fb_ring);
    ref_h[2] = ref_h[1]; ref_h[1] = ref_h[0]; ref_h[0] = int'(ref_ring);
  endtask

  task automatic tick(bit stb);
    @(negedge clk);
    if (model_on) begin
      model_step();
      check(valid === 1'(exp_valid), "R5", int'(valid), exp_valid);
      check(int'(err) == exp_err, err_tag, int'(err), exp_err);
    end
    if (fb_half > 0) begin
      fb_ph++;
      if (fb_ph >= fb_half) begin fb_ph = 0; fb_ring = ~fb_ring; end
    end
    if (ref_half > 0) begin
      ref_ph++;
      if (ref_ph >= ref_half) begin ref_ph = 0; ref_ring = ~ref_ring; end
    end
    strobe = stb;
  endtask

  task automatic run_window(int len, int count);
    for (int w = 0; w < count; w++)
      for (int i = 0; i < len; i++) tick(i == len - 1);
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst_ni = 1'b0; model_on = 0; strobe = 1'b0;
    repeat (3) @(negedge clk);
    check(valid === 1'b0, "R6", int'(valid), 0);
    check(int'(err) == 0, "R6", int'(err), 0);
    model_clear();
    rst_ni = 1'b1; model_on = 1;
  endtask

  initial begin
    #(200000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check(valid === 1'b0, "R6", int'(valid), 0);
    check(int'(err) == 0, "R6", int'(err), 0);
    rst_ni = 1'b1; model_on = 1;

    cur_tag = "R1"; fb_half = 6; ref_half = 5; run_window(120, 4);
    fb_half = 5; ref_half = 6; run_window(120, 4);
    fb_half = 7; ref_half = 7; run_window(97, 4);
    fb_half = 9; ref_half = 8; run_window(150, 3);

    cur_tag = "R4"; fb_half = 10; ref_half = 3; run_window(200, 3);
    fb_half = 3; ref_half = 10; run_window(200, 3);

    cur_tag = "R2"; fb_half = 40; ref_half = 0; run_window(50, 6);
    fb_half = 0; run_window(60, 2);

    cur_tag = "R3"; fb_half = 2; ref_half = 3;
    run_window(1, 20); run_window(2, 15); run_window(3, 15);
    fb_half = 1; ref_half = 1; run_window(1, 10); run_window(2, 10);

    cur_tag = "R7"; fb_half = 1; ref_half = 1; run_window(600, 2);
    fb_half = 1; ref_half = 2; run_window(600, 2);

    cur_tag = "R6"; fb_half = 4; ref_half = 3; run_window(30, 1);
    tick(1'b0);
    reset_check();
    run_window(80, 3);

    cur_tag = "R1"; fb_half = 8; ref_half = 6; run_window(130, 3);
    tick(1'b0); tick(1'b0); tick(1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule